// File: doc/BRIEF.md
# Three-Wire Wiper Position Controller

This block is the digital control section of a stepped resistor-tap selector. A host drives three asynchronous pins: an active-low select, an increment strobe and a direction level. The block brings them into the system clock domain, keeps a saturating tap position over `NUM_TAPS` positions and decodes that position to a one-hot tap-select bus that drives the analog switch array. No analog logic is part of the block.

A persistent register holds a saved position. On deselect, the strobe level decides what happens. If the strobe is high, the current position is written to the persistent register, and a busy window of `STORE_CYCLES` clocks follows. If the strobe is low, the block returns to standby without writing, and the live position stays in effect.

The block has two resets. `por_ni` is a cold reset that sets the persistent register to `NV_INIT`. `rst_ni` is the power-up reset. After `rst_ni` is released, the tap position is reloaded from the persistent register on the first clock edge.

Top module: `wiper_ctrl`

## Requirements
- R1: On the first clock after `rst_ni` is released, `tap_pos_o` takes the value of `nv_pos_o`. That value is `NV_INIT` after a cold reset, or the last position stored otherwise.
- R2: A high-to-low transition of `inc_i` while `sel_ni` is low and `dir_i` is high raises `tap_pos_o` by one.
- R3: A high-to-low transition of `inc_i` while `sel_ni` is low and `dir_i` is low lowers `tap_pos_o` by one.
- R4: A step up at position `NUM_TAPS-1` leaves the position at `NUM_TAPS-1`.
- R5: A step down at position 0 leaves the position at 0.
- R6: Transitions of `inc_i` while `sel_ni` is high do not change `tap_pos_o`.
- R7: A low-to-high transition of `sel_ni` while `inc_i` is high copies `tap_pos_o` into `nv_pos_o` and holds `store_busy_o` high for `STORE_CYCLES` clocks.
- R8: A low-to-high transition of `sel_ni` while `inc_i` is low leaves `nv_pos_o` unchanged and keeps the live `tap_pos_o`.
- R9: `tap_sel_o` has exactly one bit set, and that bit's index equals `tap_pos_o`.
- R10: A falling edge of `inc_i` that arrives while `store_busy_o` is high is dropped. It does not take effect after the busy window ends.
- R11: `standby_o` is high exactly when the synchronised select is high and `store_busy_o` is low.
- R12: Only the falling edge of `inc_i` moves the position. A rising edge, and any number of `dir_i` changes while selected, do not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_ni | input | 1 | Cold reset, active low; sets the persistent register to NV_INIT |
| rst_ni | input | 1 | Power-up reset, active low; the position is recalled after release |
| sel_ni | input | 1 | Asynchronous select, active low |
| inc_i | input | 1 | Asynchronous increment strobe; acts on its falling edge |
| dir_i | input | 1 | Asynchronous direction: 1 steps up, 0 steps down |
| tap_sel_o | output | NUM_TAPS | One-hot tap select |
| tap_pos_o | output | $clog2(NUM_TAPS) | Current tap position |
| nv_pos_o | output | $clog2(NUM_TAPS) | Content of the persistent register |
| store_busy_o | output | 1 | A store is in progress |
| standby_o | output | 1 | Deselected and no store pending |

## Verification
A falling strobe and a rising select can reach the synchronisers on the same clock edge. The bench provokes this by driving both pins at one instant. The select is then already high when the strobe edge is seen, so the step is blocked. The strobe is low at deselect, so no store takes place. The bench judges the outcome by checking that the position, the persistent value and the busy flag all stay unchanged while standby rises.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef struct packed {
    logic sel_n;
    logic inc;
    logic dir;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sel_n: 1'b1, inc: 1'b1, dir: 1'b0};
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/tap_counter.sv
module tap_counter #(
  parameter int NUM_TAPS = 100,
  localparam int POS_W   = $clog2(NUM_TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [POS_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             up_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(NUM_TAPS - 1);

  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (load_i)
      pos_d = load_val_i;
    else if (step_i) begin
      if (up_i)
        pos_d = (pos_q == POS_MAX) ? pos_q : pos_q + 1'b1;
      else
        pos_d = (pos_q == '0) ? pos_q : pos_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assign pos_o = pos_q;

  assert_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> (pos_q <= POS_MAX));

  assert_single_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> (pos_q == $past(pos_q) || pos_q == $past(pos_q) + 1'b1 ||
                        pos_q == $past(pos_q) - 1'b1));

  assert_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == '0 && step_i && !up_i && !load_i) |=> (pos_q == '0));
endmodule

// File: rtl/tap_decoder.sv
module tap_decoder #(
  parameter int NUM_TAPS = 100,
  localparam int POS_W   = $clog2(NUM_TAPS)
) (
  input  logic [POS_W-1:0]    pos_i,
  output logic [NUM_TAPS-1:0] sel_o
);
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign sel_o[i] = (pos_i == POS_W'(i));
  end
endmodule

// File: rtl/store_ctrl.sv
module store_ctrl #(
  parameter int NUM_TAPS     = 100,
  parameter int STORE_CYCLES = 16,
  parameter int NV_INIT      = 50,
  localparam int POS_W       = $clog2(NUM_TAPS),
  localparam int CNT_W       = $clog2(STORE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic             rst_ni,
  input  logic             store_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [POS_W-1:0] nv_o,
  output logic             busy_o
);
  logic [POS_W-1:0] nv_q;
  logic [CNT_W-1:0] busy_cnt_q;

  // persistent cell: survives the power-up reset, cleared only by por_ni
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)      nv_q <= POS_W'(NV_INIT);
    else if (store_i) nv_q <= pos_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              busy_cnt_q <= '0;
    else if (store_i)         busy_cnt_q <= CNT_W'(STORE_CYCLES);
    else if (busy_cnt_q != 0) busy_cnt_q <= busy_cnt_q - 1'b1;
  end

  assign nv_o   = nv_q;
  assign busy_o = (busy_cnt_q != '0);

  assert_nv_only_on_store_R8: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (nv_q != $past(nv_q)) |-> $past(store_i));

  assert_busy_after_store_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i |=> (busy_o && nv_q == $past(pos_i)));
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
  parameter int NUM_TAPS     = 100,
  parameter int STORE_CYCLES = 16,
  parameter int NV_INIT      = 50,
  localparam int POS_W       = $clog2(NUM_TAPS)
) (
  input  logic                clk_i,
  input  logic                por_ni,
  input  logic                rst_ni,
  input  logic                sel_ni,
  input  logic                inc_i,
  input  logic                dir_i,
  output logic [NUM_TAPS-1:0] tap_sel_o,
  output logic [POS_W-1:0]    tap_pos_o,
  output logic [POS_W-1:0]    nv_pos_o,
  output logic                store_busy_o,
  output logic                standby_o
);
  import wiper_pkg::*;

  pins_t            pins_raw, pins_s;
  logic             sel_n_q, inc_q, recall_q;
  logic             step_en, deselect, store_req, busy;
  logic [POS_W-1:0] pos, nv;

  assign pins_raw = '{sel_n: sel_ni, inc: inc_i, dir: dir_i};

  pin_sync #(.W(3), .RST_VAL(PINS_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_n_q  <= 1'b1;
      inc_q    <= 1'b1;
      recall_q <= 1'b1;
    end else begin
      sel_n_q  <= pins_s.sel_n;
      inc_q    <= pins_s.inc;
      recall_q <= 1'b0;
    end
  end

  // falling strobe while selected and idle; store only on deselect with strobe high
  assign step_en   = inc_q && !pins_s.inc && !pins_s.sel_n && !busy && !recall_q;
  assign deselect  = !sel_n_q && pins_s.sel_n;
  assign store_req = deselect && pins_s.inc;

  tap_counter #(.NUM_TAPS(NUM_TAPS)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (recall_q),
    .load_val_i(nv),
    .step_i    (step_en),
    .up_i      (pins_s.dir),
    .pos_o     (pos)
  );

  tap_decoder #(.NUM_TAPS(NUM_TAPS)) u_dec (
    .pos_i(pos),
    .sel_o(tap_sel_o)
  );

  store_ctrl #(.NUM_TAPS(NUM_TAPS), .STORE_CYCLES(STORE_CYCLES), .NV_INIT(NV_INIT)) u_store (
    .clk_i  (clk_i),
    .por_ni (por_ni),
    .rst_ni (rst_ni),
    .store_i(store_req),
    .pos_i  (pos),
    .nv_o   (nv),
    .busy_o (busy)
  );

  assign tap_pos_o    = pos;
  assign nv_pos_o     = nv;
  assign store_busy_o = busy;
  assign standby_o    = pins_s.sel_n && !busy;

  assert_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(tap_sel_o) == 1) && tap_sel_o[pos]);

  assert_busy_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(pos));

  assert_recall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_q |=> (pos == $past(nv)));

  assert_no_standby_on_store_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req |=> !standby_o);

  assert_deselect_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_s.sel_n && !recall_q) |=> $stable(pos));
endmodule

// File: tb/tb_wiper_ctrl.sv
module tb_wiper_ctrl;
  localparam int NT    = 100;
  localparam int SC    = 8;
  localparam int NVI   = 50;
  localparam int PW    = $clog2(NT);

  logic          clk = 1'b0;
  logic          por_n, rst_n, sel_n, inc, dir;
  logic [NT-1:0] tap_sel;
  logic [PW-1:0] tap_pos, nv_pos;
  logic          busy, stby;

  always #10 clk = ~clk;

  wiper_ctrl #(.NUM_TAPS(NT), .STORE_CYCLES(SC), .NV_INIT(NVI)) dut (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .sel_ni(sel_n), .inc_i(inc), .dir_i(dir),
    .tap_sel_o(tap_sel), .tap_pos_o(tap_pos), .nv_pos_o(nv_pos),
    .store_busy_o(busy), .standby_o(stby)
  );

  typedef struct {
    int    pos;
    int    nv;
    bit    stby;
    bit    busy;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  int   e_pos, e_nv;
  bit   done = 1'b0;

  task automatic settle(int n = 5);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(string tag, bit s, bit b);
    exp_t e;
    e.pos = e_pos; e.nv = e_nv; e.stby = s; e.busy = b; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  // monitor: compares at the negedge following each push
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (int'(tap_pos) != e.pos || int'(nv_pos) != e.nv || stby != e.stby || busy != e.busy) begin
          n_fail++;
          $display("FAIL %s: pos=%0d nv=%0d stby=%0b busy=%0b, expected pos=%0d nv=%0d stby=%0b busy=%0b",
                   e.tag, tap_pos, nv_pos, stby, busy, e.pos, e.nv, e.stby, e.busy);
        end
        n_run++;
        if ($countones(tap_sel) != 1 || tap_sel[tap_pos] !== 1'b1 || int'(tap_pos) != e.pos) begin
          n_fail++;
          $display("FAIL R9 (%s): tap_sel ones=%0d pos=%0d, expected single bit at %0d",
                   e.tag, $countones(tap_sel), tap_pos, e.pos);
        end
      end
    end
  end

  task automatic pulse(int n, bit up);
    dir = up;
    repeat (n) begin
      inc = 1'b0; settle();
      if (up) e_pos = (e_pos == NT - 1) ? e_pos : e_pos + 1;
      else    e_pos = (e_pos == 0) ? 0 : e_pos - 1;
      inc = 1'b1; settle();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; sel_n = 1'b1; inc = 1'b1; dir = 1'b0;
    e_pos = NVI; e_nv = NVI;
    settle(3);
    por_n = 1'b1; rst_n = 1'b1;
    settle();
    expect_now("R1 recall of NV_INIT after cold start, R11 standby", 1'b1, 1'b0);

    sel_n = 1'b0; settle();
    expect_now("R11 selected clears standby", 1'b0, 1'b0);

    pulse(3, 1'b1);
    expect_now("R2 three steps up", 1'b0, 1'b0);
    pulse(1, 1'b0);
    expect_now("R3 one step down", 1'b0, 1'b0);

    // R12: direction toggles, then a split strobe
    repeat (5) begin dir = ~dir; settle(2); end
    dir = 1'b1;
    inc = 1'b0; settle(); e_pos++;
    expect_now("R12 falling edge moves position", 1'b0, 1'b0);
    inc = 1'b1; settle();
    expect_now("R12 rising edge and dir toggles do not move", 1'b0, 1'b0);

    // R8: deselect with strobe low (falling strobe steps first)
    dir = 1'b0; inc = 1'b0; settle(); e_pos--;
    sel_n = 1'b1; settle();
    expect_now("R8 deselect with strobe low, no store", 1'b1, 1'b0);
    inc = 1'b1; settle();

    // R6: strobes while deselected
    repeat (4) begin inc = 1'b0; settle(3); inc = 1'b1; settle(3); end
    expect_now("R6 strobes while deselected ignored", 1'b1, 1'b0);

    sel_n = 1'b0; settle();
    pulse(60, 1'b1);
    expect_now("R4 saturate at top", 1'b0, 1'b0);

    // R7: deselect with strobe high
    sel_n = 1'b1; settle(4); e_nv = e_pos;
    expect_now("R7 store with busy, R11 no standby while busy", 1'b0, 1'b1);
    settle(SC + 4);
    expect_now("R7 busy window ends, R11 standby", 1'b1, 1'b0);

    // R10: strobe inside busy window
    sel_n = 1'b0; settle();
    pulse(1, 1'b0);
    sel_n = 1'b1; e_nv = e_pos;
    @(negedge clk); sel_n = 1'b0;
    @(negedge clk); inc = 1'b0;
    settle(3);
    expect_now("R10 strobe during busy dropped", 1'b0, 1'b1);
    settle(SC + 4);
    expect_now("R10 dropped edge not replayed", 1'b0, 1'b0);
    inc = 1'b1; settle();

    pulse(NT + 10, 1'b0);
    expect_now("R5 saturate at bottom", 1'b0, 1'b0);

    // R1: power-up recall of stored value
    sel_n = 1'b1; inc = 1'b0; settle();
    expect_now("R8 deselect at zero without store", 1'b1, 1'b0);
    inc = 1'b1; settle();
    rst_n = 1'b0; settle(2); rst_n = 1'b1; settle();
    e_pos = e_nv;
    expect_now("R1 recall of stored value after power-up", 1'b1, 1'b0);

    // same-cycle: strobe falls as select rises
    sel_n = 1'b0; settle();
    pulse(1, 1'b0);
    sel_n = 1'b1; inc = 1'b0; settle();
    expect_now("R6 R8 strobe fall coincident with deselect", 1'b1, 1'b0);
    inc = 1'b1; settle();
    expect_now("R12 rising strobe after deselect", 1'b1, 1'b0);

    settle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule